// File: doc/BRIEF.md
# Reconfigurable Look-Up-Table Cell Pair

This block models two 4-input look-up-table cells that share one storage array per cell. A parameter fixes the function of the pair for its whole life. In table mode, each cell is a fixed Boolean function of four inputs, read from a 16-bit truth table. In shift mode, each cell is a 16-stage shift register whose output stage is picked by the address inputs. In the three memory modes, the two cells act together as one of three memories: a 32-word by 1-bit memory, a 16-word by 2-bit memory, or a 16-word by 1-bit memory with two read ports.

Storage is loaded from the `INIT_LO` and `INIT_HI` parameters, and loaded again by a synchronous active-low reset. Writes and shifts take place on the rising clock edge when `we` is high. Reads are combinational from the addresses, so a written value appears on `dout` in the cycle after the write edge.

Top module: `lutp_pair`

## Requirements
- R1: In table mode (`PAIR_MODE` = PM_LOGIC), `dout[0]` equals bit `addr_a[3:0]` of `INIT_LO` and `dout[1]` equals bit `addr_b` of `INIT_HI`. This holds at all times: a high `we` does not change either output.
- R2: While `rst_n` is low at a rising edge, every cell that stores data loads its initial contents. Reset wins over a write in the same cycle. After reset, reads return the parameter bits.
- R3: In the memory modes, `we` high at a rising edge stores the data bit at the write address. During the write cycle, `dout` still shows the old word. In the next cycle it shows the new word.
- R4: In 32x1 mode (PM_RAM32X1), `addr_a[4]` picks the bank. A value of 0 selects the low cell, whose word k starts as bit k of `INIT_LO`. A value of 1 selects the high cell, whose word k starts as bit k of `INIT_HI`. The bank bit steers both the write enable and the read of `din[0]` onto `dout[0]`. `dout[1]` stays 0.
- R5: In 16x2 mode (PM_RAM16X2), both bits of `din` are written at `addr_a[3:0]`, and `dout` returns both bits of that word. Bit 0 comes from the `INIT_LO` cell.
- R6: In dual-port mode (PM_DUAL16), port A writes `din[0]` and reads `dout[0]` at `addr_a[3:0]`. Port B reads `dout[1]` at `addr_b`. Both ports start from `INIT_LO`, so they see one shared memory.
- R7: In shift mode (PM_SHIFT), `we` high at an edge moves stage k-1 into stage k and loads `din[0]` (low cell) or `din[1]` (high cell) into stage 0. `dout[0]` shows stage `addr_a[3:0]` of the low cell, and `dout[1]` shows stage `addr_b` of the high cell. Initial stage k is bit k of its parameter.
- R8: With `we` low, no storage changes, whatever `din` and the addresses do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reload of initial contents |
| we | input | 1 | Write / shift enable |
| din | input | 2 | Write or shift-in data, bit 1 for the high cell |
| addr_a | input | AW+1 | Port A address; top bit is the bank select in 32x1 mode |
| addr_b | input | AW | Port B read / high-cell tap address |
| dout | output | 2 | Read data, bit 1 from the high cell or port B |

## Verification
A write or shift can share a cycle with a read of the very location it changes, and in dual-port mode port B can read the word that port A is writing. The bench drives `we` high while both addresses point at the written word. It then expects the old value during that cycle and the new value in the cycle after. Five copies of the pair, one per mode, receive the same stimulus. Each copy is compared against its own reference model in a scoreboard.

// File: rtl/lutp_pkg.sv
`timescale 1ns/1ps
package lutp_pkg;

   typedef enum logic [2:0] {
      PM_LOGIC,
      PM_SHIFT,
      PM_RAM16X2,
      PM_RAM32X1,
      PM_DUAL16
   } pair_mode_e;

   typedef enum logic [1:0] {
      CM_TABLE,
      CM_MEMORY,
      CM_SHIFTER
   } cell_mode_e;

   function automatic cell_mode_e cell_mode_of(input pair_mode_e pm);
      case (pm)
         PM_LOGIC: return CM_TABLE;
         PM_SHIFT: return CM_SHIFTER;
         default:  return CM_MEMORY;
      endcase
   endfunction

endpackage

// File: rtl/lutp_cell.sv
`timescale 1ns/1ps
module lutp_cell
   import lutp_pkg::*;
#(
   parameter cell_mode_e            MODE = CM_MEMORY,
   parameter int unsigned           AW   = 4,
   parameter logic [(1<<AW)-1:0]    INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_data,
   input  logic [AW-1:0] wr_addr,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_data
);

   localparam int unsigned DEPTH = 1 << AW;

   logic [DEPTH-1:0] store;

   if (AW < 1 || AW > 6) begin : g_bad_aw
      $error("lutp_cell: AW must lie in 1..6");
   end

   if (MODE == CM_TABLE) begin : g_table
      wire unused_tbl = ^{clk, rst_n, wr_en, wr_data, wr_addr};
      assign store = INIT;
   end else if (MODE == CM_MEMORY) begin : g_memory
      always_ff @(posedge clk) begin
         if (!rst_n)
            store <= INIT;
         else if (wr_en)
            store[wr_addr] <= wr_data;
      end

      a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |=> store[$past(wr_addr)] == $past(wr_data));

      a_r8_memory_holds: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_en |=> $stable(store));

      a_r2_memory_reload: assert property (@(posedge clk)
         !rst_n |=> store == INIT);
   end else begin : g_shifter
      wire unused_sh = ^wr_addr;
      always_ff @(posedge clk) begin
         if (!rst_n)
            store <= INIT;
         else if (wr_en)
            store <= {store[DEPTH-2:0], wr_data};
      end

      a_r7_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |=> (store[0] == $past(wr_data)) &&
                   (store[DEPTH-1:1] == $past(store[DEPTH-2:0])));

      a_r8_shift_holds: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_en |=> $stable(store));

      a_r2_shift_reload: assert property (@(posedge clk)
         !rst_n |=> store == INIT);
   end

   assign rd_data = store[rd_addr];

endmodule

// File: rtl/lutp_steer.sv
`timescale 1ns/1ps
module lutp_steer
   import lutp_pkg::*;
#(
   parameter pair_mode_e  MODE = PM_RAM32X1,
   parameter int unsigned AW   = 4
) (
   input  logic          we,
   input  logic [1:0]    din,
   input  logic [AW:0]   addr_a,
   input  logic [AW-1:0] addr_b,
   input  logic [1:0]    rd_data,
   output logic [1:0]    wr_en,
   output logic [1:0]    wr_data,
   output logic [AW-1:0] wr_addr_lo,
   output logic [AW-1:0] wr_addr_hi,
   output logic [AW-1:0] rd_addr_lo,
   output logic [AW-1:0] rd_addr_hi,
   output logic [1:0]    dout
);

   logic [AW-1:0] word_a;
   logic          bank_a;

   assign word_a = addr_a[AW-1:0];
   assign bank_a = addr_a[AW];

   if (MODE == PM_LOGIC) begin : g_logic
      wire unused_lg = ^{we, din, bank_a};
      assign wr_en      = 2'b00;
      assign wr_data    = 2'b00;
      assign wr_addr_lo = word_a;
      assign wr_addr_hi = addr_b;
      assign rd_addr_lo = word_a;
      assign rd_addr_hi = addr_b;
      assign dout       = rd_data;
   end else if (MODE == PM_SHIFT) begin : g_shift
      wire unused_sh = bank_a;
      assign wr_en      = {we, we};
      assign wr_data    = din;
      assign wr_addr_lo = word_a;
      assign wr_addr_hi = addr_b;
      assign rd_addr_lo = word_a;
      assign rd_addr_hi = addr_b;
      assign dout       = rd_data;
   end else if (MODE == PM_RAM16X2) begin : g_wide
      wire unused_wd = ^{addr_b, bank_a};
      assign wr_en      = {we, we};
      assign wr_data    = din;
      assign wr_addr_lo = word_a;
      assign wr_addr_hi = word_a;
      assign rd_addr_lo = word_a;
      assign rd_addr_hi = word_a;
      assign dout       = rd_data;
   end else if (MODE == PM_RAM32X1) begin : g_deep
      wire unused_dp = ^{addr_b, din[1]};
      assign wr_en      = {we & bank_a, we & ~bank_a};
      assign wr_data    = {din[0], din[0]};
      assign wr_addr_lo = word_a;
      assign wr_addr_hi = word_a;
      assign rd_addr_lo = word_a;
      assign rd_addr_hi = word_a;
      assign dout       = {1'b0, bank_a ? rd_data[1] : rd_data[0]};
   end else begin : g_dual
      wire unused_du = ^{din[1], bank_a};
      assign wr_en      = {we, we};
      assign wr_data    = {din[0], din[0]};
      assign wr_addr_lo = word_a;
      assign wr_addr_hi = word_a;
      assign rd_addr_lo = word_a;
      assign rd_addr_hi = addr_b;
      assign dout       = rd_data;
   end

endmodule

// File: rtl/lutp_pair.sv
`timescale 1ns/1ps
module lutp_pair
   import lutp_pkg::*;
#(
   parameter pair_mode_e          PAIR_MODE = PM_RAM32X1,
   parameter int unsigned         AW        = 4,
   parameter logic [(1<<AW)-1:0]  INIT_LO   = 16'hA5C3,
   parameter logic [(1<<AW)-1:0]  INIT_HI   = 16'h3C96
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [1:0]    din,
   input  logic [AW:0]   addr_a,
   input  logic [AW-1:0] addr_b,
   output logic [1:0]    dout
);

   localparam int unsigned        DEPTH   = 1 << AW;
   localparam cell_mode_e         CMODE   = cell_mode_of(PAIR_MODE);
   localparam logic [DEPTH-1:0]   HI_INIT = (PAIR_MODE == PM_DUAL16) ? INIT_LO : INIT_HI;

   if (AW < 2 || AW > 6) begin : g_bad_aw
      $error("lutp_pair: AW must lie in 2..6");
   end

   logic [1:0]    c_wr_en;
   logic [1:0]    c_wr_data;
   logic [1:0]    c_rd_data;
   logic [AW-1:0] wa_lo, wa_hi, ra_lo, ra_hi;

   lutp_steer #(.MODE(PAIR_MODE), .AW(AW)) u_steer (
      .we        (we),
      .din       (din),
      .addr_a    (addr_a),
      .addr_b    (addr_b),
      .rd_data   (c_rd_data),
      .wr_en     (c_wr_en),
      .wr_data   (c_wr_data),
      .wr_addr_lo(wa_lo),
      .wr_addr_hi(wa_hi),
      .rd_addr_lo(ra_lo),
      .rd_addr_hi(ra_hi),
      .dout      (dout)
   );

   lutp_cell #(.MODE(CMODE), .AW(AW), .INIT(INIT_LO)) u_lo (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (c_wr_en[0]),
      .wr_data(c_wr_data[0]),
      .wr_addr(wa_lo),
      .rd_addr(ra_lo),
      .rd_data(c_rd_data[0])
   );

   lutp_cell #(.MODE(CMODE), .AW(AW), .INIT(HI_INIT)) u_hi (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (c_wr_en[1]),
      .wr_data(c_wr_data[1]),
      .wr_addr(wa_hi),
      .rd_addr(ra_hi),
      .rd_data(c_rd_data[1])
   );

   if (PAIR_MODE == PM_DUAL16) begin : g_dual_chk
      a_r6_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
         (addr_b == addr_a[AW-1:0]) |-> (dout[0] == dout[1]));
   end

   if (PAIR_MODE == PM_RAM32X1) begin : g_deep_chk
      a_r4_bank_steer: assert property (@(posedge clk) disable iff (!rst_n)
         (we && addr_a[AW]) |=> $stable(u_lo.store));
   end

endmodule

// File: tb/sim_lutp_pair.sv
`timescale 1ns/1ps
module sim_lutp_pair;
   import lutp_pkg::*;

   localparam logic [15:0] I_LO = 16'hA5C3;
   localparam logic [15:0] I_HI = 16'h3C96;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       we = 1'b0;
   logic [1:0] din = 2'b00;
   logic [4:0] addr_a = '0;
   logic [3:0] addr_b = '0;
   logic [1:0] d0, d1, d2, d3, d4;

   always #4 clk = ~clk;

   lutp_pair #(.PAIR_MODE(PM_RAM32X1), .INIT_LO(I_LO), .INIT_HI(I_HI)) u0 (
      .clk(clk), .rst_n(rst_n), .we(we), .din(din), .addr_a(addr_a), .addr_b(addr_b), .dout(d0));
   lutp_pair #(.PAIR_MODE(PM_LOGIC), .INIT_LO(I_LO), .INIT_HI(I_HI)) u1 (
      .clk(clk), .rst_n(rst_n), .we(we), .din(din), .addr_a(addr_a), .addr_b(addr_b), .dout(d1));
   lutp_pair #(.PAIR_MODE(PM_RAM16X2), .INIT_LO(I_LO), .INIT_HI(I_HI)) u2 (
      .clk(clk), .rst_n(rst_n), .we(we), .din(din), .addr_a(addr_a), .addr_b(addr_b), .dout(d2));
   lutp_pair #(.PAIR_MODE(PM_DUAL16), .INIT_LO(I_LO), .INIT_HI(I_HI)) u3 (
      .clk(clk), .rst_n(rst_n), .we(we), .din(din), .addr_a(addr_a), .addr_b(addr_b), .dout(d3));
   lutp_pair #(.PAIR_MODE(PM_SHIFT), .INIT_LO(I_LO), .INIT_HI(I_HI)) u4 (
      .clk(clk), .rst_n(rst_n), .we(we), .din(din), .addr_a(addr_a), .addr_b(addr_b), .dout(d4));

   typedef struct {
      int         unit;
      logic [1:0] exp;
      string      tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // reference models
   logic [31:0] m32;
   logic [15:0] w_lo, w_hi, dp, s_lo, s_hi;

   task automatic models_init();
      m32  = {I_HI, I_LO};
      w_lo = I_LO; w_hi = I_HI;
      dp   = I_LO;
      s_lo = I_LO; s_hi = I_HI;
   endtask

   task automatic push(input int u, input logic [1:0] e, input string t);
      sb_item_t it;
      it.unit = u; it.exp = e; it.tag = t;
      sb_q.push_back(it);
   endtask

   // driver: applies one cycle of stimulus and queues what each mode must show
   task automatic step(input logic w, input logic [1:0] di, input logic [4:0] aa,
                       input logic [3:0] ab, input string t);
      @(negedge clk);
      we = w; din = di; addr_a = aa; addr_b = ab;
      push(0, {1'b0, m32[aa]},                  {"R4/", t});
      push(1, {I_HI[ab], I_LO[aa[3:0]]},        {"R1/", t});
      push(2, {w_hi[aa[3:0]], w_lo[aa[3:0]]},   {"R5/", t});
      push(3, {dp[ab], dp[aa[3:0]]},            {"R6/", t});
      push(4, {s_hi[ab], s_lo[aa[3:0]]},        {"R7/", t});
      if (w) begin
         m32[aa]        = di[0];
         w_lo[aa[3:0]]  = di[0];
         w_hi[aa[3:0]]  = di[1];
         dp[aa[3:0]]    = di[0];
         s_lo           = {s_lo[14:0], di[0]};
         s_hi           = {s_hi[14:0], di[1]};
      end
   endtask

   // R2: reset asserted with a write pending; reset must win
   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; we = 1'b1; din = 2'b11; addr_a = 5'd0; addr_b = 4'd0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1; we = 1'b0;
      models_init();
   endtask

   // monitor: compares every queued item shortly after the inputs settle
   always begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
         sb_item_t it;
         logic [1:0] act;
         it = sb_q.pop_front();
         case (it.unit)
            0: act = d0;
            1: act = d1;
            2: act = d2;
            3: act = d3;
            default: act = d4;
         endcase
         n_checks++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s unit %0d: actual %b expected %b", it.tag, it.unit, act, it.exp);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      models_init();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 / R1: reset state across both banks, port B walking down
      for (int i = 0; i < 32; i++)
         step(1'b0, 2'b00, 5'(i), 4'(15 - (i % 16)), "R2_reset_state");

      // R3 / R7: writes and shifts; each cycle expects pre-edge contents
      for (int i = 0; i < 32; i++)
         step(1'b1, {i[1] ^ i[3], i[0] ^ i[2] ^ i[4]}, 5'(i), 4'(i % 16), "R3_write_cycle");

      // R3: readback in the following cycles
      for (int i = 0; i < 32; i++)
         step(1'b0, 2'b00, 5'(31 - i), 4'(i % 16), "R3_readback");

      // R6: port B reads the word port A writes, same cycle then next
      step(1'b1, 2'b10, 5'd7, 4'd7, "R6_same_cycle");
      step(1'b0, 2'b00, 5'd7, 4'd7, "R6_next_cycle");
      step(1'b1, 2'b01, 5'd7, 4'd7, "R6_same_cycle");
      step(1'b0, 2'b00, 5'd7, 4'd7, "R6_next_cycle");

      // R4: bank select with the high bit only; low bank must keep its word
      step(1'b1, 2'b01, 5'd19, 4'd3, "R4_high_bank");
      step(1'b0, 2'b00, 5'd3, 4'd3, "R4_low_untouched");
      step(1'b0, 2'b00, 5'd19, 4'd3, "R4_high_readback");

      // R8: data and addresses toggle with we low; nothing may change
      for (int i = 0; i < 16; i++)
         step(1'b0, 2'(i), 5'(i * 3), 4'(i), "R8_idle");

      // R7: fill the shifters with a known pattern, then walk every tap
      for (int i = 0; i < 16; i++)
         step(1'b1, {i[0], i[1] ^ i[2]}, 5'(i), 4'(15 - i), "R7_fill");
      for (int i = 0; i < 16; i++)
         step(1'b0, 2'b11, 5'(i), 4'(15 - i), "R7_tap_walk");

      // R2: mid-run reset with a write pending returns the initial contents
      do_reset();
      for (int i = 0; i < 32; i++)
         step(1'b0, 2'b00, 5'(i), 4'(i % 16), "R2_reload");

      @(negedge clk);
      #3;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule